// File: doc/BRIEF.md
# Indirect Message-Bus Register Bridge

The bridge lets a host reach registers that live behind an internal message bus. Toward the host it has two 32-bit registers: a command register and a data register. Every access takes two steps. For a store, the host first places the value in the data register and then writes a command word. For a fetch, the host writes the command word, waits for the busy flag to clear, and then reads the data register.

A command word holds four fields: opcode, target port, target register offset and byte enables. When the command is legal, the bridge sends a single-cycle request on the message port. It holds busy until the target answers. A fetch merges the answer into the data register, byte by byte, under the byte enables. A store sends the staged data word unchanged.

An unknown opcode or an unmapped port sends nothing and sets an error flag. Both flags sit in the low bits of the command register, which otherwise read as zero.

Top module: `mbb_bridge`

## Requirements
- R1: After reset the command register and the data register both read 0, and no request is issued.
- R2: The command register is at host offset 0xD0 and the data register at 0xD4. Any other offset reads 0, and writes to it change nothing.
- R3: The command register reads back the opcode in [31:24], the port in [23:16], the register offset in [15:8] and the byte enables in [7:4]. Bits [3:2] always read 0, whatever was written to them.
- R4: A command with opcode 0xE0 and a mapped port sends exactly one request, in the cycle after the command write. The request has write=1, the latched port, offset and byte enables, and the staged data word. The response to a store leaves the data register unchanged.
- R5: A command with opcode 0xD0 and a mapped port sends one request with write=1 cleared. On the response, each data-register byte whose enable is set takes the response byte, and every other byte keeps its old value. Enable bit i covers bits [8i+7:8i].
- R6: Bit 0 of the command register (busy) reads 1 from the cycle after a legal command until the response is accepted, and 0 after that.
- R7: While busy, a read of the data register returns the previous value. Host writes to either register are ignored.
- R8: An opcode other than 0xD0/0xE0, or a port at or above NUM_PORTS (default 4, so port 0x3 is mapped), sends no request and keeps busy at 0. It sets bit 1 of the command register and leaves the data register unchanged. The next legal command clears bit 1.
- R9: A response that arrives while the bridge is not busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on host_addr) |
| msg_req_valid | output | 1 | One-cycle request strobe |
| msg_req_write | output | 1 | 1 = store, 0 = fetch |
| msg_req_port | output | 8 | Target port |
| msg_req_offset | output | 8 | Target register offset |
| msg_req_be | output | 4 | Byte enables |
| msg_req_data | output | 32 | Store data |
| msg_rsp_valid | input | 1 | Target response strobe |
| msg_rsp_data | input | 32 | Fetch response data |

## Verification
The bench stages data before a store command. A design that sampled the data at the wrong moment would send a stale word, and the scoreboard would see it. A fetch uses sparse byte enables; a design that overwrote the whole word would lose the kept bytes. While busy, the bench writes to both registers, and a design that accepted those writes would corrupt the next read. Illegal opcodes and the port at the mapping boundary must produce no request, and a spurious idle response must leave the data untouched. A design that failed either check would show a request the scoreboard does not expect, or a changed data word.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    localparam logic [7:0] OP_FETCH = 8'hD0;
    localparam logic [7:0] OP_STORE = 8'hE0;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] port;
        logic [7:0] reg_ofs;
        logic [3:0] be;
        logic [3:0] rsvd;
    } cmd_word_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

    function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  be);
        logic [31:0] r;
        r = old_w;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/mbb_cmd_check.sv
module mbb_cmd_check
    import mbb_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  cmd_word_t cmd,
    output logic      legal,
    output logic      is_store
);
    logic op_ok;
    logic port_ok;

    always_comb begin
        op_ok    = (cmd.opcode == OP_FETCH) || (cmd.opcode == OP_STORE);
        port_ok  = (32'(cmd.port) < NUM_PORTS);
        legal    = op_ok && port_ok;
        is_store = (cmd.opcode == OP_STORE);
    end
endmodule

// File: rtl/mbb_seq.sv
module mbb_seq
    import mbb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic rsp_valid,
    output logic busy,
    output logic req_valid,
    output logic rsp_accept
);
    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE:  if (launch) state <= SEQ_ISSUE;
                SEQ_ISSUE: state <= SEQ_WAIT;
                SEQ_WAIT:  if (rsp_valid) state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state != SEQ_IDLE);
        req_valid  = (state == SEQ_ISSUE);
        rsp_accept = (state == SEQ_WAIT) && rsp_valid;
    end

    assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    assert_busy_ends_on_rsp_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(rsp_valid));
endmodule

// File: rtl/mbb_data_reg.sv
module mbb_data_reg
    import mbb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              host_load,
    input  logic [DATA_W-1:0] host_data,
    input  logic              rsp_load,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [3:0]        be,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (rsp_load) begin
            q <= byte_merge(q, rsp_data, be);
        end else if (host_load) begin
            q <= host_data;
        end
    end

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_load) |=> $stable(q));
endmodule

// File: rtl/mbb_bridge.sv
module mbb_bridge
    import mbb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_PORTS = 4,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'('hD0),
    parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'('hD4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              msg_req_valid,
    output logic              msg_req_write,
    output logic [7:0]        msg_req_port,
    output logic [7:0]        msg_req_offset,
    output logic [3:0]        msg_req_be,
    output logic [31:0]       msg_req_data,
    input  logic              msg_rsp_valid,
    input  logic [31:0]       msg_rsp_data
);
    localparam int DATA_W = 32;

    cmd_word_t   wcmd;
    cmd_word_t   cur;
    logic        err_q;
    logic        store_q;
    logic        legal;
    logic        is_store;
    logic        busy;
    logic        req_valid;
    logic        rsp_accept;
    logic        cmd_wr;
    logic        data_wr;
    logic        launch;
    logic [31:0] data_q;

    assign wcmd    = cmd_word_t'(host_wdata);
    assign cmd_wr  = host_wr && (host_addr == CMD_ADDR) && !busy;
    assign data_wr = host_wr && (host_addr == DATA_ADDR) && !busy;
    assign launch  = cmd_wr && legal;

    mbb_cmd_check #(.NUM_PORTS(NUM_PORTS)) u_check (
        .cmd      (wcmd),
        .legal    (legal),
        .is_store (is_store)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            err_q   <= 1'b0;
            store_q <= 1'b0;
        end else if (cmd_wr) begin
            cur.opcode  <= wcmd.opcode;
            cur.port    <= wcmd.port;
            cur.reg_ofs <= wcmd.reg_ofs;
            cur.be      <= wcmd.be;
            cur.rsvd    <= 4'h0;
            err_q       <= !legal;
            store_q     <= is_store;
        end
    end

    mbb_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .rsp_valid  (msg_rsp_valid),
        .busy       (busy),
        .req_valid  (req_valid),
        .rsp_accept (rsp_accept)
    );

    mbb_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .host_load (data_wr),
        .host_data (host_wdata),
        .rsp_load  (rsp_accept && !store_q),
        .rsp_data  (msg_rsp_data),
        .be        (cur.be),
        .q         (data_q)
    );

    always_comb begin
        msg_req_valid  = req_valid;
        msg_req_write  = store_q;
        msg_req_port   = cur.port;
        msg_req_offset = cur.reg_ofs;
        msg_req_be     = cur.be;
        msg_req_data   = data_q;
    end

    always_comb begin
        if (host_addr == CMD_ADDR)
            host_rdata = {cur.opcode, cur.port, cur.reg_ofs, cur.be, 2'b00, err_q, busy};
        else if (host_addr == DATA_ADDR)
            host_rdata = data_q;
        else
            host_rdata = '0;
    end

    assert_bad_cmd_no_req_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !legal) |=> (!msg_req_valid && !busy));

    assert_idle_rsp_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && msg_rsp_valid && !data_wr) |=> $stable(data_q));
endmodule

// File: tb/tb_mbb_bridge.sv
module tb_mbb_bridge;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [7:0]  port;
        logic [7:0]  ofs;
        logic [3:0]  be;
        logic [31:0] data;
    } req_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        msg_req_valid, msg_req_write;
    logic [7:0]  msg_req_port, msg_req_offset;
    logic [3:0]  msg_req_be;
    logic [31:0] msg_req_data;
    logic        msg_rsp_valid = 1'b0;
    logic [31:0] msg_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    req_item_t exp_q[$];

    mbb_bridge dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .msg_req_valid(msg_req_valid), .msg_req_write(msg_req_write),
        .msg_req_port(msg_req_port), .msg_req_offset(msg_req_offset),
        .msg_req_be(msg_req_be), .msg_req_data(msg_req_data),
        .msg_rsp_valid(msg_rsp_valid), .msg_rsp_data(msg_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Monitor: every request is popped from the scoreboard and compared.
    always @(negedge clk) begin
        if (!rst && msg_req_valid) begin
            req_item_t got, e;
            got = '{msg_req_write, msg_req_port, msg_req_offset, msg_req_be, msg_req_data};
            if (exp_q.size() == 0) begin
                check_eq("R8 unexpected request", {31'd0, 1'b1}, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check_eq(e.wr ? "R4 req data" : "R5 req data", got.data & {32{e.wr}}, e.data & {32{e.wr}});
                check_eq("R4/R5 req header", {11'd0, got.wr, got.port, got.ofs, got.be},
                         {11'd0, e.wr, e.port, e.ofs, e.be});
            end
        end
    end

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Driver: writes a command and pushes the expected request when legal.
    task automatic issue(input logic [31:0] w, input bit legal, input logic [31:0] staged);
        if (legal) exp_q.push_back('{w[31:24] == 8'hE0, w[23:16], w[15:8], w[7:4], staged});
        host_write(8'hD0, w);
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        host_addr = a;
        #1;
        check_eq(tag, host_rdata, exp);
    endtask

    task automatic respond(input logic [31:0] d);
        @(negedge clk);
        msg_rsp_valid = 1'b1; msg_rsp_data = d;
        @(negedge clk);
        msg_rsp_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        read_check("R1 cmd after reset", 8'hD0, 32'h0);
        read_check("R1 data after reset", 8'hD4, 32'h0);
        check_eq("R1 no request", {31'd0, msg_req_valid}, 32'd0);

        // R2 decode
        host_write(8'h10, 32'hDEADBEEF);
        read_check("R2 unmapped read", 8'h10, 32'h0);
        read_check("R2 unmapped write cmd", 8'hD0, 32'h0);
        read_check("R2 unmapped write data", 8'hD4, 32'h0);

        // R4 store: stage then command
        host_write(8'hD4, 32'hA5A51234);
        read_check("R2 data readback", 8'hD4, 32'hA5A51234);
        issue(32'hE00312F0, 1'b1, 32'hA5A51234);
        read_check("R6 busy after store cmd", 8'hD0, 32'hE00312F1);
        // R7 writes ignored while busy
        host_write(8'hD4, 32'h00000000);
        host_write(8'hD0, 32'hD0010000);
        read_check("R7 data held while busy", 8'hD4, 32'hA5A51234);
        read_check("R7 cmd held while busy", 8'hD0, 32'hE00312F1);
        respond(32'h77777777);
        read_check("R6 busy clears", 8'hD0, 32'hE00312F0);
        read_check("R4 store rsp keeps data", 8'hD4, 32'hA5A51234);

        // R5 fetch with reserved bits set (R3)
        issue(32'hD00310FF, 1'b1, 32'h0);
        read_check("R3 reserved bits read zero", 8'hD0, 32'hD00310F1);
        read_check("R7 stale data while busy", 8'hD4, 32'hA5A51234);
        respond(32'h2FFFFC00);
        read_check("R5 full fetch", 8'hD4, 32'h2FFFFC00);

        // R5 partial byte enables 0x5
        host_write(8'hD4, 32'h11223344);
        issue(32'hD0000850, 1'b1, 32'h0);
        respond(32'hAABBCCDD);
        read_check("R5 partial merge", 8'hD4, 32'h11BB33DD);

        // R8 bad opcode
        issue(32'h550310F0, 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        read_check("R8 bad opcode error", 8'hD0, 32'h550310F2);
        read_check("R8 data unchanged", 8'hD4, 32'h11BB33DD);
        // R8 boundary port 4
        issue(32'hD00400F0, 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        read_check("R8 port boundary error", 8'hD0, 32'hD00400F2);
        // legal command clears error
        issue(32'hE00020F0, 1'b1, 32'h11BB33DD);
        read_check("R8 error cleared", 8'hD0, 32'hE00020F1);
        respond(32'h0);

        // R9 idle response ignored
        respond(32'hFFFFFFFF);
        read_check("R9 idle rsp data", 8'hD4, 32'h11BB33DD);
        read_check("R9 idle rsp status", 8'hD0, 32'hE00020F0);

        repeat (2) @(negedge clk);
        check_eq("R4 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule